// File: doc/BRIEF.md
# Margin Command Sequencer

This block is a hardware state machine that takes over the relay work a driver would otherwise do during receiver lane margining. A neighbouring relay register block raises events: readiness when the link reaches the margining data rate, start or change when new margin control data has been captured, and stop when the link partner ends margining. The sequencer sends each captured control word to the PHY through a request/acknowledge mailbox. It then polls the PHY for margin status at a fixed interval and writes every result back into the relay block's status and flag registers.

There are three active paths. The control path issues a set-control request and a flag write, then waits out a settle delay. The polling path fetches status, writes the status register and the flags, and then waits out a poll delay. The stop path issues one last set-control request and, after the settle delay, writes flags with the PHY status bit cleared before it goes idle. Events are latched as pending and are acted on at defined decision points. A mailbox error or timeout drops the sequencer back to idle and pulses an error output. Both delays are cycle counts derived from a clock frequency parameter, so a simulation can shorten them.

Top module: `margin_seq`

## Requirements
- R1: While reset is asserted and right after it, `mb_req_o`, `wr_en_o` and `err_o` are low.
- R2: A readiness event seen in idle, with no start, change or stop pending, produces a single flag write (`wr_sel_o`=0) of 0x3. Flag bits: bit0 software-ready, bit1 ready, bit2 PHY status, bit3 error status.
- R3: A start or change event produces a mailbox request with command 0 (set control), lane `LANE_ID`, and a payload equal to the captured 23-bit control word: bit0 enable, bit1 clear, bits 8:2 x, bits 14:9 y, bits 22:15 block count. The payload stays stable while the request waits for its acknowledge.
- R4: A successful set-control acknowledge is followed in the next cycle by a flag write of 0xF.
- R5: The first get-status request (command 1) follows the 0xF flag write by SETTLE_CYC+1 cycles, where SETTLE_CYC = (CLK_HZ/1e6)·SETTLE_US.
- R6: A successful get-status acknowledge causes a status register write (`wr_sel_o`=1) of the returned word in the next cycle, followed at once by a flag write of 0xB.
- R7: Polling repeats. Each later get-status request comes POLL_CYC+1 cycles after the preceding 0xB flag write, where POLL_CYC = (CLK_HZ/1e6)·POLL_US, and each one carries fresh data.
- R8: A stop event triggers a set-control request and a 0xF flag write. SETTLE_CYC+1 cycles later comes a 0xB flag write, after which the sequencer is idle and issues no further requests.
- R9: Events are held pending until the next decision point: idle, the end of the settle delay, or the end of the poll delay. When stop and start are pending together, stop wins.
- R10: An acknowledge with the error qualifier abandons the step. The sequencer returns to idle with no register write, and `err_o` is high for exactly one cycle.
- R11: If no acknowledge arrives within TIMEOUT cycles, the request is held for exactly TIMEOUT cycles and then dropped. `err_o` pulses once and no register write follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| evt_ready_i | input | 1 | Readiness event pulse |
| evt_start_i | input | 1 | Margin start event pulse |
| evt_change_i | input | 1 | Margin change event pulse |
| evt_stop_i | input | 1 | Margin stop event pulse |
| ctrl_i | input | 23 | Current margin control register contents |
| wr_en_o | output | 1 | Register write strobe toward the relay block |
| wr_sel_o | output | 1 | Write target: 0 flags, 1 margin status |
| wr_data_o | output | STAT_W | Write data |
| mb_req_o | output | 1 | Mailbox request, held until acknowledge or timeout |
| mb_lane_o | output | LANE_W | Lane identifier |
| mb_cmd_o | output | 1 | Command: 0 set control, 1 get status |
| mb_payload_o | output | 23 | Control payload (zero for get status) |
| mb_ack_i | input | 1 | Mailbox acknowledge, one cycle |
| mb_err_i | input | 1 | Error qualifier valid with acknowledge |
| mb_rdata_i | input | STAT_W | Status word returned with acknowledge |
| err_o | output | 1 | One-cycle pulse on mailbox error or timeout |

## Verification
The assertions assume that the mailbox raises its acknowledge only while a request is pending, that it holds the acknowledge for one cycle, and that it presents the error qualifier and the returned data in that same cycle. The bench's responder follows this contract. It answers on the first sampled cycle of each request and clears its signals on the next, and it can be told to stay silent to force a timeout. Events are driven as single-cycle pulses. Later events are timed to land in the poll or settle wait, so that each decision point is exercised with a known pending set.

// File: rtl/msq_pkg.sv
package msq_pkg;
  typedef struct packed {
    logic [7:0] nblks;
    logic [5:0] y;
    logic [6:0] x;
    logic       clr;
    logic       en;
  } msq_ctrl_t;

  localparam int unsigned CTRL_W = $bits(msq_ctrl_t);

  typedef enum logic [3:0] {
    S_IDLE, S_RFLG, S_CREQ, S_CFLG, S_SETTLE, S_SFLG,
    S_GREQ, S_GSTAT, S_GFLG, S_POLL
  } msq_state_e;

  localparam logic CMD_SET = 1'b0;
  localparam logic CMD_GET = 1'b1;

  // flag bit order is decoded by the relay block
  localparam logic [3:0] FLG_SW_RDY = 4'b0001;
  localparam logic [3:0] FLG_RDY    = 4'b0010;
  localparam logic [3:0] FLG_PHY    = 4'b0100;
  localparam logic [3:0] FLG_ERR    = 4'b1000;
endpackage

// File: rtl/msq_evt.sv
module msq_evt (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic evt_ready_i,
  input  logic evt_start_i,
  input  logic evt_change_i,
  input  logic evt_stop_i,
  input  logic clr_cmd_i,
  input  logic clr_rdy_i,
  output logic pend_rdy_o,
  output logic pend_start_o,
  output logic pend_stop_o
);
  // new events win over a same-cycle clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_rdy_o   <= 1'b0;
      pend_start_o <= 1'b0;
      pend_stop_o  <= 1'b0;
    end else begin
      pend_rdy_o   <= (pend_rdy_o & ~(clr_rdy_i | clr_cmd_i)) | evt_ready_i;
      pend_start_o <= (pend_start_o & ~clr_cmd_i) | evt_start_i | evt_change_i;
      pend_stop_o  <= (pend_stop_o & ~clr_cmd_i) | evt_stop_i;
    end
  end
endmodule

// File: rtl/msq_timer.sv
module msq_timer #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  output logic         done_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_q <= '0;
    else if (load_i)           cnt_q <= val_i;
    else if (cnt_q != '0)      cnt_q <= cnt_q - 1'b1;
  end

  assign done_o = (cnt_q == '0);

  p_load_value_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (cnt_q == $past(val_i)));
endmodule

// File: rtl/msq_mbox.sv
module msq_mbox #(
  parameter int unsigned TIMEOUT = 64
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic active_i,
  input  logic ack_i,
  input  logic err_i,
  output logic ok_o,
  output logic fail_o
);
  localparam int unsigned CW = $clog2(TIMEOUT + 1);
  localparam logic [CW-1:0] LAST = CW'(TIMEOUT - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        cnt_q <= '0;
    else if (!active_i) cnt_q <= '0;
    else                cnt_q <= cnt_q + 1'b1;
  end

  assign ok_o   = active_i & ack_i & ~err_i;
  assign fail_o = active_i & ((ack_i & err_i) | (~ack_i & (cnt_q == LAST)));

  p_wait_bounded_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active_i |-> (cnt_q <= LAST));
endmodule

// File: rtl/margin_seq.sv
module margin_seq
  import msq_pkg::*;
#(
  parameter int unsigned CLK_HZ    = 100_000_000,
  parameter int unsigned SETTLE_US = 10,
  parameter int unsigned POLL_US   = 20_000,
  parameter int unsigned TIMEOUT   = 1024,
  parameter int unsigned LANE_W    = 5,
  parameter int unsigned LANE_ID   = 0,
  parameter int unsigned STAT_W    = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              evt_ready_i,
  input  logic              evt_start_i,
  input  logic              evt_change_i,
  input  logic              evt_stop_i,
  input  logic [CTRL_W-1:0] ctrl_i,
  output logic              wr_en_o,
  output logic              wr_sel_o,
  output logic [STAT_W-1:0] wr_data_o,
  output logic              mb_req_o,
  output logic [LANE_W-1:0] mb_lane_o,
  output logic              mb_cmd_o,
  output logic [CTRL_W-1:0] mb_payload_o,
  input  logic              mb_ack_i,
  input  logic              mb_err_i,
  input  logic [STAT_W-1:0] mb_rdata_i,
  output logic              err_o
);
  localparam int unsigned CYC_US     = (CLK_HZ / 1_000_000 == 0) ? 1 : CLK_HZ / 1_000_000;
  localparam int unsigned SETTLE_CYC = (CYC_US * SETTLE_US == 0) ? 1 : CYC_US * SETTLE_US;
  localparam int unsigned POLL_CYC   = (CYC_US * POLL_US == 0) ? 1 : CYC_US * POLL_US;
  localparam int unsigned MAX_CYC    = (POLL_CYC > SETTLE_CYC) ? POLL_CYC : SETTLE_CYC;
  localparam int unsigned TMR_W      = $clog2(MAX_CYC + 1);

  msq_state_e  state_q, state_n;
  msq_ctrl_t   ctrl_q;
  logic        stop_q;
  logic [STAT_W-1:0] stat_q;
  logic        err_q;

  logic pend_rdy, pend_start, pend_stop;
  logic take_cmd, take_rdy, go_cmd;
  logic tmr_load, tmr_done;
  logic [TMR_W-1:0] tmr_val;
  logic mbx_active, mbx_ok, mbx_fail;

  msq_evt u_evt (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .evt_ready_i  (evt_ready_i),
    .evt_start_i  (evt_start_i),
    .evt_change_i (evt_change_i),
    .evt_stop_i   (evt_stop_i),
    .clr_cmd_i    (take_cmd),
    .clr_rdy_i    (take_rdy),
    .pend_rdy_o   (pend_rdy),
    .pend_start_o (pend_start),
    .pend_stop_o  (pend_stop)
  );

  msq_timer #(.W(TMR_W)) u_tmr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (tmr_load),
    .val_i  (tmr_val),
    .done_o (tmr_done)
  );

  assign mbx_active = (state_q == S_CREQ) || (state_q == S_GREQ);

  msq_mbox #(.TIMEOUT(TIMEOUT)) u_mbx (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .active_i (mbx_active),
    .ack_i    (mb_ack_i),
    .err_i    (mb_err_i),
    .ok_o     (mbx_ok),
    .fail_o   (mbx_fail)
  );

  assign go_cmd = pend_start | pend_stop;

  always_comb begin
    state_n  = state_q;
    take_cmd = 1'b0;
    take_rdy = 1'b0;
    tmr_load = 1'b0;
    tmr_val  = '0;
    unique case (state_q)
      S_IDLE: begin
        if (go_cmd) begin
          take_cmd = 1'b1;
          state_n  = S_CREQ;
        end else if (pend_rdy) begin
          take_rdy = 1'b1;
          state_n  = S_RFLG;
        end
      end
      S_RFLG:  state_n = S_IDLE;
      S_CREQ: begin
        if (mbx_ok)        state_n = S_CFLG;
        else if (mbx_fail) state_n = S_IDLE;
      end
      S_CFLG: begin
        tmr_load = 1'b1;
        tmr_val  = TMR_W'(SETTLE_CYC - 1);
        state_n  = S_SETTLE;
      end
      S_SETTLE: begin
        if (tmr_done) begin
          if (stop_q) state_n = S_SFLG;
          else if (go_cmd) begin
            take_cmd = 1'b1;
            state_n  = S_CREQ;
          end else state_n = S_GREQ;
        end
      end
      S_SFLG:  state_n = S_IDLE;
      S_GREQ: begin
        if (mbx_ok)        state_n = S_GSTAT;
        else if (mbx_fail) state_n = S_IDLE;
      end
      S_GSTAT: state_n = S_GFLG;
      S_GFLG: begin
        tmr_load = 1'b1;
        tmr_val  = TMR_W'(POLL_CYC - 1);
        state_n  = S_POLL;
      end
      S_POLL: begin
        if (tmr_done) begin
          if (go_cmd) begin
            take_cmd = 1'b1;
            state_n  = S_CREQ;
          end else state_n = S_GREQ;
        end
      end
      default: state_n = S_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      ctrl_q  <= '0;
      stop_q  <= 1'b0;
      stat_q  <= '0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_n;
      err_q   <= mbx_fail;
      if (take_cmd) begin
        ctrl_q <= msq_ctrl_t'(ctrl_i);
        stop_q <= pend_stop;   // stop outranks start
      end
      if ((state_q == S_GREQ) && mbx_ok) stat_q <= mb_rdata_i;
    end
  end

  always_comb begin
    wr_en_o   = 1'b0;
    wr_sel_o  = 1'b0;
    wr_data_o = '0;
    unique case (state_q)
      S_RFLG: begin
        wr_en_o   = 1'b1;
        wr_data_o = STAT_W'(FLG_SW_RDY | FLG_RDY);
      end
      S_CFLG: begin
        wr_en_o   = 1'b1;
        wr_data_o = STAT_W'(FLG_SW_RDY | FLG_RDY | FLG_PHY | FLG_ERR);
      end
      S_SFLG, S_GFLG: begin
        wr_en_o   = 1'b1;
        wr_data_o = STAT_W'(FLG_SW_RDY | FLG_RDY | FLG_ERR);
      end
      S_GSTAT: begin
        wr_en_o   = 1'b1;
        wr_sel_o  = 1'b1;
        wr_data_o = stat_q;
      end
      default: ;
    endcase
  end

  assign mb_req_o     = mbx_active;
  assign mb_lane_o    = LANE_W'(LANE_ID);
  assign mb_cmd_o     = (state_q == S_GREQ) ? CMD_GET : CMD_SET;
  assign mb_payload_o = (state_q == S_CREQ) ? CTRL_W'(ctrl_q) : '0;
  assign err_o        = err_q;

  p_fail_flags_err_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mbx_fail |=> (err_o && !wr_en_o && !mb_req_o));

  p_err_single_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> !err_o);

  p_payload_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mb_req_o && !mb_ack_i && !mbx_fail) |=> (mb_req_o && $stable(mb_payload_o)));

  p_status_data_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mb_req_o && mb_cmd_o && mb_ack_i && !mb_err_i) |=>
      (wr_en_o && wr_sel_o && wr_data_o == $past(mb_rdata_i)));

  p_status_then_flags_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_o && wr_sel_o) |=> (wr_en_o && !wr_sel_o && wr_data_o == STAT_W'(4'hB)));

  p_ctrl_ack_flags_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mb_req_o && !mb_cmd_o && mb_ack_i && !mb_err_i) |=>
      (wr_en_o && !wr_sel_o && wr_data_o == STAT_W'(4'hF)));
endmodule

// File: tb/margin_seq_test.sv
module margin_seq_test;
  localparam int unsigned CLK_HZ  = 1_000_000;
  localparam int unsigned SET_US  = 10;
  localparam int unsigned POLL_US = 60;
  localparam int unsigned TO      = 16;
  localparam int unsigned LANE    = 5;
  localparam int unsigned SET_CYC = SET_US;
  localparam int unsigned POL_CYC = POLL_US;

  // {control word, returned status}
  localparam logic [63:0] VEC [4] = '{
    {32'h0000_0001, 32'h0000_1234},
    {32'h007F_FFFF, 32'hABCD_FFFF},
    {32'h0055_2A03, 32'h0000_0000},
    {32'h0000_41FD, 32'h5A5A_00C3}
  };

  logic clk = 1'b0, rst_ni = 1'b0;
  logic evt_ready_i = 0, evt_start_i = 0, evt_change_i = 0, evt_stop_i = 0;
  logic [22:0] ctrl_i = '0;
  logic wr_en_o, wr_sel_o, mb_req_o, mb_cmd_o, err_o;
  logic [15:0] wr_data_o;
  logic [4:0]  mb_lane_o;
  logic [22:0] mb_payload_o;
  logic mb_ack_i = 0, mb_err_i = 0;
  logic [15:0] mb_rdata_i = '0;

  logic resp_en = 1'b1, resp_err = 1'b0;
  logic [31:0] resp_data = '0;

  int n_cmp = 0, n_bad = 0;
  int cyc = 0, wn = 0, mn = 0, err_cnt = 0, req_run = 0, req_run_last = 0;
  logic        wl_sel [256];
  logic [15:0] wl_dat [256];
  int          wl_t   [256];
  logic        ml_cmd [256];
  logic [22:0] ml_pay [256];
  logic [4:0]  ml_lane[256];
  int          ml_t   [256];
  logic        prev_req = 1'b0;
  bit          done = 1'b0;

  always #5 clk = ~clk;

  margin_seq #(
    .CLK_HZ(CLK_HZ), .SETTLE_US(SET_US), .POLL_US(POLL_US), .TIMEOUT(TO),
    .LANE_W(5), .LANE_ID(LANE), .STAT_W(16)
  ) uut (
    .clk_i(clk), .rst_ni(rst_ni),
    .evt_ready_i(evt_ready_i), .evt_start_i(evt_start_i),
    .evt_change_i(evt_change_i), .evt_stop_i(evt_stop_i),
    .ctrl_i(ctrl_i),
    .wr_en_o(wr_en_o), .wr_sel_o(wr_sel_o), .wr_data_o(wr_data_o),
    .mb_req_o(mb_req_o), .mb_lane_o(mb_lane_o), .mb_cmd_o(mb_cmd_o),
    .mb_payload_o(mb_payload_o), .mb_ack_i(mb_ack_i), .mb_err_i(mb_err_i),
    .mb_rdata_i(mb_rdata_i), .err_o(err_o)
  );

  // monitor and mailbox responder, away from the active edge
  initial begin
    forever begin
      @(negedge clk);
      cyc++;
      mb_ack_i = 1'b0;
      mb_err_i = 1'b0;
      if (rst_ni) begin
        if (wr_en_o && wn < 256) begin
          wl_sel[wn] = wr_sel_o; wl_dat[wn] = wr_data_o; wl_t[wn] = cyc; wn++;
        end
        if (mb_req_o && !prev_req && mn < 256) begin
          ml_cmd[mn] = mb_cmd_o; ml_pay[mn] = mb_payload_o;
          ml_lane[mn] = mb_lane_o; ml_t[mn] = cyc; mn++;
        end
        if (err_o) err_cnt++;
        if (mb_req_o) req_run++;
        else if (prev_req) begin req_run_last = req_run; req_run = 0; end
        prev_req = mb_req_o;
        if (mb_req_o && resp_en) begin
          mb_ack_i   = 1'b1;
          mb_err_i   = resp_err;
          mb_rdata_i = resp_data[15:0];
        end
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic pulse(input logic r, input logic s, input logic c, input logic p);
    @(negedge clk);
    evt_ready_i = r; evt_start_i = s; evt_change_i = c; evt_stop_i = p;
    @(negedge clk);
    evt_ready_i = 0; evt_start_i = 0; evt_change_i = 0; evt_stop_i = 0;
  endtask

  task automatic wait_writes(input int target);
    for (int k = 0; k < 3000 && wn < target; k++) @(negedge clk);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (200_000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    int wb, mb, eb;
    idle(3);
    // R1: reset state
    chk("R1 req in reset", 32'(mb_req_o), 0);
    chk("R1 wr in reset", 32'(wr_en_o), 0);
    chk("R1 err in reset", 32'(err_o), 0);
    rst_ni = 1'b1;
    idle(3);
    chk("R1 idle after reset", {30'd0, mb_req_o, wr_en_o}, 0);

    // R2: readiness in idle
    pulse(1, 0, 0, 0);
    idle(10);
    chk("R2 write count", 32'(wn), 1);
    chk("R2 flag target", 32'(wl_sel[0]), 0);
    chk("R2 flag value", 32'(wl_dat[0]), 32'h3);
    chk("R2 no request", 32'(mn), 0);

    // R3..R6, R9: vector walk; later vectors land in the poll wait
    for (int i = 0; i < 4; i++) begin
      wb = wn; mb = mn;
      ctrl_i    = VEC[i][54:32];
      resp_data = VEC[i][31:0];
      if (i % 2 == 0) pulse(0, 1, 0, 0); else pulse(0, 0, 1, 0);
      wait_writes(wb + 3);
      chk("R3 set cmd", 32'(ml_cmd[mb]), 0);
      chk("R3 lane", 32'(ml_lane[mb]), LANE);
      chk("R3 payload", 32'(ml_pay[mb]), 32'(VEC[i][54:32]));
      chk("R4 flags after control", {15'd0, wl_sel[wb], wl_dat[wb]}, 32'h0000_000F);
      chk("R5 get cmd", 32'(ml_cmd[mb+1]), 1);
      chk("R5 settle gap", 32'(ml_t[mb+1] - wl_t[wb]), SET_CYC + 1);
      chk("R6 status write", {15'd0, wl_sel[wb+1], wl_dat[wb+1]}, {15'd0, 1'b1, VEC[i][15:0]});
      chk("R6 flags after status", {15'd0, wl_sel[wb+2], wl_dat[wb+2]}, 32'h0000_000B);
      if (i > 0) chk("R9 event taken at poll end", 32'(mn - mb), 2);
    end

    // R7: repeat poll with fresh data
    wb = wn; mb = mn;
    resp_data = 32'h0000_7E81;
    wait_writes(wb + 2);
    chk("R7 poll cmd", 32'(ml_cmd[mb]), 1);
    chk("R7 poll gap", 32'(ml_t[mb] - wl_t[wb-1]), POL_CYC + 1);
    chk("R7 fresh status", {15'd0, wl_sel[wb], wl_dat[wb]}, 32'h0001_7E81);

    // R8: stop from the poll wait
    wb = wn; mb = mn;
    pulse(0, 0, 0, 1);
    wait_writes(wb + 2);
    idle(3 * POL_CYC);
    chk("R8 one request", 32'(mn - mb), 1);
    chk("R8 set cmd", 32'(ml_cmd[mb]), 0);
    chk("R8 payload", 32'(ml_pay[mb]), 32'(VEC[3][54:32]));
    chk("R8 two writes", 32'(wn - wb), 2);
    chk("R8 first flags", 32'(wl_dat[wb]), 32'hF);
    chk("R8 stop flags", {15'd0, wl_sel[wb+1], wl_dat[wb+1]}, 32'h0000_000B);
    chk("R8 stop gap", 32'(wl_t[wb+1] - wl_t[wb]), SET_CYC + 1);

    // R9: start and stop together from idle, stop wins
    wb = wn; mb = mn;
    ctrl_i = 23'h12345;
    pulse(0, 1, 0, 1);
    idle(3 * POL_CYC);
    chk("R9 single request", 32'(mn - mb), 1);
    chk("R9 payload", 32'(ml_pay[mb]), 32'h12345);
    chk("R9 stop path writes", 32'(wn - wb), 2);
    chk("R9 stop path flags", 32'(wl_dat[wb+1]), 32'hB);

    // R10: error acknowledge
    wb = wn; mb = mn; eb = err_cnt;
    resp_err = 1'b1;
    pulse(0, 1, 0, 0);
    idle(3 * POL_CYC);
    resp_err = 1'b0;
    chk("R10 err pulses", 32'(err_cnt - eb), 1);
    chk("R10 no writes", 32'(wn - wb), 0);
    chk("R10 single request", 32'(mn - mb), 1);

    // R11: timeout
    wb = wn; mb = mn; eb = err_cnt;
    resp_en = 1'b0;
    pulse(0, 1, 0, 0);
    idle(TO + 20);
    resp_en = 1'b1;
    idle(5);
    chk("R11 err pulses", 32'(err_cnt - eb), 1);
    chk("R11 request length", 32'(req_run_last), TO);
    chk("R11 no writes", 32'(wn - wb), 0);
    chk("R11 single request", 32'(mn - mb), 1);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule